// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides how an executing load obtains its data. A load arrives with its address, byte size, sequence number, load-queue slot and the store-queue position captured when it was dispatched. The block then walks the store queue backwards from that position, one entry per cycle, through a read port into storage held elsewhere. It stops at the first live store that touches the load's bytes, or at the writeback pointer.

There are four outcomes. A store that fully covers the load forwards its data, shifted to the load's byte offset. A store that only partly overlaps sends the load back for replay. If no store overlaps, the load goes to memory. An uncacheable load that is still speculative is refused with a fault indication.

On a replay the block holds a single stall record for the oldest such load and the store blocking it. When that store's writeback is reported, the record clears and a replay-ready pulse names the load slot.

Top module: `stlf_checker`

## Requirements
- R1: Starting from the recorded index, each scan step first compares the current index with `wb_ptr`. If they are equal the scan ends with result 0 (memory). Otherwise it steps to the next older entry, wrapping from 0 to SQ_DEPTH-1, and examines that entry. The first entry that decides the outcome (the youngest one) wins.
- R2: An entry whose size is zero never decides the outcome, and the scan moves on past it.
- R3: When store address <= load address and load address + load size <= store address + store size, the result is 1 (forward). `fwd_data` is then the store data shifted right by 8 × (load address AND (store size − 1)). For every other result `fwd_data` is zero.
- R4: A partial overlap with a store not yet written gives result 2 (replay) and ends the scan. A partial overlap with a store flagged as written is passed over.
- R5: On result 2 the stall record takes the store's sequence number and the load's slot. If a record already exists, it is replaced only when the new load's sequence number is smaller.
- R6: `st_wb_valid` with a sequence number equal to the recorded store clears `stall_active`. On the next cycle it gives a one-cycle `replay_ready` with the recorded load slot. A non-matching sequence number changes nothing.
- R7: An uncacheable load that is not both at the load-queue head and at commit ends after one step with result 3 (fault), without scanning and without touching the stall record. When both flags are set, it is scanned like any other load.
- R8: `done` is a one-cycle pulse that rises exactly S cycles after acceptance, where S is the number of scan steps. `busy` is high while scanning, and a request presented while busy is ignored.
- R9: After reset, `done`, `busy`, `stall_active` and `replay_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request, taken when not busy |
| req_addr | input | AW | Load byte address |
| req_size | input | SZW | Load size in bytes |
| req_seq | input | SEQW | Load sequence number (smaller is older) |
| req_lq_idx | input | LW | Load-queue slot of the load |
| req_sq_idx | input | IW | Store-queue position recorded at dispatch |
| req_uncached | input | 1 | Load is uncacheable |
| req_at_head | input | 1 | Load is at the load-queue head |
| req_at_commit | input | 1 | Load has reached commit |
| busy | output | 1 | Scan in progress |
| wb_ptr | input | IW | Store writeback index; scan boundary |
| sq_rd_idx | output | IW | Store-queue entry being examined |
| sq_rd_addr | input | AW | Address of examined store |
| sq_rd_size | input | SZW | Size of examined store, zero if unknown |
| sq_rd_data | input | DW | Data of examined store |
| sq_rd_seq | input | SEQW | Sequence number of examined store |
| sq_rd_written | input | 1 | Examined store already written back |
| st_wb_valid | input | 1 | A store writeback completed |
| st_wb_seq | input | SEQW | Sequence number of that store |
| done | output | 1 | Result valid pulse |
| result | output | 2 | 0 memory, 1 forward, 2 replay, 3 fault |
| fwd_data | output | DW | Forwarded, shifted store data |
| stall_active | output | 1 | Stall record held |
| stall_store_seq | output | SEQW | Store blocking the stalled load |
| stall_load_idx | output | LW | Slot of the stalled load |
| replay_ready | output | 1 | Stalled load may now replay |
| replay_load_idx | output | LW | Slot to replay |

## Verification
Random store queues use small aligned addresses and sizes of 0, 1, 2, 4 and 8 bytes, so full coverage, partial overlap and disjoint ranges all occur often. A bench scan model predicts the result, the data, the step count and the stall record for each load. Directed queues then separate the remaining cases. They check youngest-versus-older coverage, wraparound past index zero and skipping of empty entries. They check a written partial store against an unwritten one and the older-versus-younger replacement of the stall record. They check matching against stray writeback sequence numbers, the two uncacheable gating outcomes, and a request held high while busy.

// File: rtl/stlf_pkg.sv
package stlf_pkg;

    typedef enum logic [1:0] {
        RES_MEM    = 2'd0,
        RES_FWD    = 2'd1,
        RES_REPLAY = 2'd2,
        RES_FAULT  = 2'd3
    } res_e;

    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_SCAN = 1'b1
    } mode_e;

endpackage

// File: rtl/stlf_idx_step.sv
module stlf_idx_step #(
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic [IW-1:0] cur,
    output logic [IW-1:0] older
);
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            always_comb older = cur - IW'(1);
        end else begin : g_mod
            always_comb older = (cur == '0) ? IW'(DEPTH - 1) : cur - IW'(1);
        end
    endgenerate
endmodule

// File: rtl/stlf_overlap.sv
module stlf_overlap #(
    parameter int AW  = 16,
    parameter int DW  = 64,
    parameter int SZW = 4
) (
    input  logic [AW-1:0]  ld_addr,
    input  logic [SZW-1:0] ld_size,
    input  logic [AW-1:0]  st_addr,
    input  logic [SZW-1:0] st_size,
    input  logic [DW-1:0]  st_data,
    output logic           covers,
    output logic           partial,
    output logic [DW-1:0]  shifted
);
    localparam int EW = AW + 1;
    localparam int SHW = SZW + 3;

    logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
    logic in_lo, in_hi, lo_touch, hi_touch;
    logic [SZW-1:0] byte_off;
    logic [SHW-1:0] bit_shift;

    always_comb begin
        ld_lo     = EW'(ld_addr);
        st_lo     = EW'(st_addr);
        ld_hi     = ld_lo + EW'(ld_size);
        st_hi     = st_lo + EW'(st_size);
        in_lo     = ld_lo >= st_lo;
        in_hi     = ld_hi <= st_hi;
        lo_touch  = ld_lo < st_hi;
        hi_touch  = ld_hi > st_lo;
        covers    = in_lo && in_hi;
        partial   = !covers && ((in_lo && lo_touch) || (in_hi && hi_touch) ||
                                (lo_touch && hi_touch));
        byte_off  = ld_addr[SZW-1:0] & (st_size - SZW'(1));
        bit_shift = {byte_off, 3'b000};
        shifted   = st_data >> bit_shift;
    end
endmodule

// File: rtl/stlf_stall_track.sv
module stlf_stall_track #(
    parameter int SEQW = 16,
    parameter int LW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_valid,
    input  logic [SEQW-1:0] set_ld_seq,
    input  logic [LW-1:0]   set_ld_idx,
    input  logic [SEQW-1:0] set_st_seq,
    input  logic            wb_valid,
    input  logic [SEQW-1:0] wb_seq,
    output logic            active,
    output logic [SEQW-1:0] st_seq,
    output logic [LW-1:0]   ld_idx,
    output logic            ready,
    output logic [LW-1:0]   ready_idx
);
    typedef struct packed {
        logic            active;
        logic [SEQW-1:0] st_seq;
        logic [SEQW-1:0] ld_seq;
        logic [LW-1:0]   ld_idx;
        logic            ready;
        logic [LW-1:0]   ready_idx;
    } trk_t;

    trk_t trk_q, trk_d;
    logic hit_wb;

    always_comb begin
        trk_d = trk_q;
        trk_d.ready = 1'b0;
        hit_wb = trk_q.active && wb_valid && (wb_seq == trk_q.st_seq);
        if (hit_wb) begin
            trk_d.active    = 1'b0;
            trk_d.ready     = 1'b1;
            trk_d.ready_idx = trk_q.ld_idx;
        end
        if (set_valid && (!trk_d.active || (set_ld_seq < trk_d.ld_seq))) begin
            trk_d.active = 1'b1;
            trk_d.st_seq = set_st_seq;
            trk_d.ld_seq = set_ld_seq;
            trk_d.ld_idx = set_ld_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign active    = trk_q.active;
    assign st_seq    = trk_q.st_seq;
    assign ld_idx    = trk_q.ld_idx;
    assign ready     = trk_q.ready;
    assign ready_idx = trk_q.ready_idx;

    assert_clear_on_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wb_valid && wb_seq == st_seq && !set_valid)
        |=> (!active && ready && ready_idx == $past(ld_idx)));

    assert_keep_older_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !wb_valid && set_valid && set_ld_seq >= trk_q.ld_seq)
        |=> (st_seq == $past(st_seq) && ld_idx == $past(ld_idx)));
endmodule

// File: rtl/stlf_checker.sv
module stlf_checker
    import stlf_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 64,
    parameter int SZW      = 4,
    parameter int SEQW     = 16,
    parameter int SQ_DEPTH = 8,
    parameter int LQ_DEPTH = 16,
    localparam int IW      = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1,
    localparam int LW      = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [SZW-1:0]  req_size,
    input  logic [SEQW-1:0] req_seq,
    input  logic [LW-1:0]   req_lq_idx,
    input  logic [IW-1:0]   req_sq_idx,
    input  logic            req_uncached,
    input  logic            req_at_head,
    input  logic            req_at_commit,
    output logic            busy,
    input  logic [IW-1:0]   wb_ptr,
    output logic [IW-1:0]   sq_rd_idx,
    input  logic [AW-1:0]   sq_rd_addr,
    input  logic [SZW-1:0]  sq_rd_size,
    input  logic [DW-1:0]   sq_rd_data,
    input  logic [SEQW-1:0] sq_rd_seq,
    input  logic            sq_rd_written,
    input  logic            st_wb_valid,
    input  logic [SEQW-1:0] st_wb_seq,
    output logic            done,
    output logic [1:0]      result,
    output logic [DW-1:0]   fwd_data,
    output logic            stall_active,
    output logic [SEQW-1:0] stall_store_seq,
    output logic [LW-1:0]   stall_load_idx,
    output logic            replay_ready,
    output logic [LW-1:0]   replay_load_idx
);
    typedef struct packed {
        mode_e           mode;
        logic [IW-1:0]   cur;
        logic [AW-1:0]   addr;
        logic [SZW-1:0]  size;
        logic [SEQW-1:0] seq;
        logic [LW-1:0]   lq;
        logic            unc;
        logic            head;
        logic            commit;
        logic            done;
        res_e            res;
        logic [DW-1:0]   data;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [IW-1:0] older_idx;
    logic          ov_covers, ov_partial;
    logic [DW-1:0] ov_shifted;
    logic          fault_now, at_wb, set_stall;

    stlf_idx_step #(.DEPTH(SQ_DEPTH), .IW(IW)) u_step (
        .cur   (ctl_q.cur),
        .older (older_idx)
    );

    stlf_overlap #(.AW(AW), .DW(DW), .SZW(SZW)) u_ovl (
        .ld_addr (ctl_q.addr),
        .ld_size (ctl_q.size),
        .st_addr (sq_rd_addr),
        .st_size (sq_rd_size),
        .st_data (sq_rd_data),
        .covers  (ov_covers),
        .partial (ov_partial),
        .shifted (ov_shifted)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        set_stall = 1'b0;
        fault_now = ctl_q.unc && !(ctl_q.head && ctl_q.commit);
        at_wb     = ctl_q.cur == wb_ptr;
        unique case (ctl_q.mode)
            MODE_IDLE: begin
                if (req_valid) begin
                    ctl_d.mode   = MODE_SCAN;
                    ctl_d.cur    = req_sq_idx;
                    ctl_d.addr   = req_addr;
                    ctl_d.size   = req_size;
                    ctl_d.seq    = req_seq;
                    ctl_d.lq     = req_lq_idx;
                    ctl_d.unc    = req_uncached;
                    ctl_d.head   = req_at_head;
                    ctl_d.commit = req_at_commit;
                end
            end
            MODE_SCAN: begin
                if (fault_now) begin
                    ctl_d.mode = MODE_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.res  = RES_FAULT;
                    ctl_d.data = '0;
                end else if (at_wb) begin
                    ctl_d.mode = MODE_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.res  = RES_MEM;
                    ctl_d.data = '0;
                end else begin
                    ctl_d.cur = older_idx;
                    if (sq_rd_size != '0) begin
                        if (ov_covers) begin
                            ctl_d.mode = MODE_IDLE;
                            ctl_d.done = 1'b1;
                            ctl_d.res  = RES_FWD;
                            ctl_d.data = ov_shifted;
                        end else if (ov_partial && !sq_rd_written) begin
                            ctl_d.mode = MODE_IDLE;
                            ctl_d.done = 1'b1;
                            ctl_d.res  = RES_REPLAY;
                            ctl_d.data = '0;
                            set_stall  = 1'b1;
                        end
                    end
                end
            end
            default: ctl_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    stlf_stall_track #(.SEQW(SEQW), .LW(LW)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_valid  (set_stall),
        .set_ld_seq (ctl_q.seq),
        .set_ld_idx (ctl_q.lq),
        .set_st_seq (sq_rd_seq),
        .wb_valid   (st_wb_valid),
        .wb_seq     (st_wb_seq),
        .active     (stall_active),
        .st_seq     (stall_store_seq),
        .ld_idx     (stall_load_idx),
        .ready      (replay_ready),
        .ready_idx  (replay_load_idx)
    );

    assign busy      = ctl_q.mode == MODE_SCAN;
    assign sq_rd_idx = older_idx;
    assign done      = ctl_q.done;
    assign result    = ctl_q.res;
    assign fwd_data  = ctl_q.data;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_done_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_wb_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fault_now && at_wb) |=> (done && result == RES_MEM));

    assert_uncached_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != RES_FAULT && ctl_q.unc) |-> (ctl_q.head && ctl_q.commit));

    assert_replay_records_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_REPLAY) |-> stall_active);

    assert_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != RES_FWD) |-> (fwd_data == '0));
endmodule

// File: tb/test_stlf_checker.sv
module test_stlf_checker;
    localparam int AW = 16, DW = 64, SZW = 4, SEQW = 16, SQD = 8, LQD = 16;
    localparam int IW = 3, LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            req_valid = 1'b0;
    logic [AW-1:0]   l_addr = '0;
    logic [SZW-1:0]  l_size = '0;
    logic [SEQW-1:0] l_seq = '0;
    logic [LW-1:0]   l_lq = '0;
    logic [IW-1:0]   l_sq = '0;
    logic            l_unc = 1'b0, l_head = 1'b0, l_commit = 1'b0;
    logic [IW-1:0]   wb_ptr = '0;
    logic            wbv = 1'b0;
    logic [SEQW-1:0] wbs = '0;

    logic [AW-1:0]   q_addr [SQD];
    logic [SZW-1:0]  q_size [SQD];
    logic [DW-1:0]   q_data [SQD];
    logic [SEQW-1:0] q_seq  [SQD];
    logic            q_wr   [SQD];

    logic [IW-1:0]   rd_idx;
    logic            busy, done, stall_active, replay_ready;
    logic [1:0]      result;
    logic [DW-1:0]   fwd_data;
    logic [SEQW-1:0] stall_store_seq;
    logic [LW-1:0]   stall_load_idx, replay_load_idx;

    stlf_checker #(.AW(AW), .DW(DW), .SZW(SZW), .SEQW(SEQW), .SQ_DEPTH(SQD),
                   .LQ_DEPTH(LQD)) i_stlf_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(l_addr),
        .req_size(l_size), .req_seq(l_seq), .req_lq_idx(l_lq), .req_sq_idx(l_sq),
        .req_uncached(l_unc), .req_at_head(l_head), .req_at_commit(l_commit),
        .busy(busy), .wb_ptr(wb_ptr), .sq_rd_idx(rd_idx),
        .sq_rd_addr(q_addr[rd_idx]), .sq_rd_size(q_size[rd_idx]),
        .sq_rd_data(q_data[rd_idx]), .sq_rd_seq(q_seq[rd_idx]),
        .sq_rd_written(q_wr[rd_idx]), .st_wb_valid(wbv), .st_wb_seq(wbs),
        .done(done), .result(result), .fwd_data(fwd_data),
        .stall_active(stall_active), .stall_store_seq(stall_store_seq),
        .stall_load_idx(stall_load_idx), .replay_ready(replay_ready),
        .replay_load_idx(replay_load_idx)
    );

    int n_chk = 0, n_bad = 0;
    logic            m_stall = 1'b0;
    logic [SEQW-1:0] m_st_seq = '0, m_ld_seq = '0;
    logic [LW-1:0]   m_ld_idx = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bench scan model
    task automatic ref_scan(output logic [1:0] r, output logic [63:0] dat,
                            output int steps, output logic [SEQW-1:0] sseq);
        int cur = int'(l_sq);
        dat = '0; steps = 0; sseq = '0; r = 2'd0;
        if (l_unc && !(l_head && l_commit)) begin
            r = 2'd3; steps = 1; return;
        end
        for (int k = 0; k <= SQD + 1; k++) begin
            int la, ls, sa, ss;
            steps++;
            if (cur == int'(wb_ptr)) begin r = 2'd0; return; end
            cur = (cur + SQD - 1) % SQD;
            ss = int'(q_size[cur]);
            if (ss == 0) continue;
            la = int'(l_addr); ls = int'(l_size); sa = int'(q_addr[cur]);
            if (la >= sa && la + ls <= sa + ss) begin
                r = 2'd1;
                dat = q_data[cur] >> (((la & (ss - 1)) & 15) * 8);
                return;
            end
            if (!q_wr[cur] && (((la >= sa) && (la < sa + ss)) ||
                               ((la + ls <= sa + ss) && (la + ls > sa)) ||
                               ((la < sa + ss) && (la + ls > sa)))) begin
                r = 2'd2; sseq = q_seq[cur]; return;
            end
        end
    endtask

    task automatic clear_sq();
        for (int i = 0; i < SQD; i++) begin
            q_addr[i] = '0; q_size[i] = '0; q_data[i] = '0;
            q_seq[i] = SEQW'(100 + i); q_wr[i] = 1'b0;
        end
    endtask

    task automatic set_ld(input int a, input int s, input int seq, input int lq,
                          input int sq, input int wb, input logic u,
                          input logic h, input logic c);
        l_addr = AW'(a); l_size = SZW'(s); l_seq = SEQW'(seq); l_lq = LW'(lq);
        l_sq = IW'(sq); wb_ptr = IW'(wb); l_unc = u; l_head = h; l_commit = c;
    endtask

    task automatic run_load(input string tag, input bit hold);
        logic [1:0] er; logic [63:0] ed; int es; logic [SEQW-1:0] ess;
        int lat = 0;
        ref_scan(er, ed, es, ess);
        req_valid = 1'b1;
        @(posedge clk); #1;
        if (hold) begin
            l_addr = l_addr + AW'(1); l_sq = l_sq + IW'(1);
        end else req_valid = 1'b0;
        while (!done && lat < 40) begin
            @(posedge clk); #1; lat++;
        end
        req_valid = 1'b0;
        chk({tag, " R1/R3/R4/R7 result"}, 64'(result), 64'(er));
        chk({tag, " R3 data"}, fwd_data, ed);
        chk({tag, " R8 latency"}, 64'(lat), 64'(es));
        if (er == 2'd2 && (!m_stall || l_seq < m_ld_seq)) begin
            m_stall = 1'b1; m_st_seq = ess; m_ld_seq = l_seq; m_ld_idx = l_lq;
        end
        chk({tag, " R5 stall"}, 64'(stall_active), 64'(m_stall));
        if (m_stall) begin
            chk({tag, " R5 store seq"}, 64'(stall_store_seq), 64'(m_st_seq));
            chk({tag, " R5 load idx"}, 64'(stall_load_idx), 64'(m_ld_idx));
        end
        @(posedge clk); #1;
        chk({tag, " R8 done pulse"}, 64'(done), 64'd0);
    endtask

    task automatic wb_pulse(input string tag, input logic [SEQW-1:0] s);
        logic hit = m_stall && (s == m_st_seq);
        logic [LW-1:0] idx = m_ld_idx;
        wbv = 1'b1; wbs = s;
        @(posedge clk); #1;
        wbv = 1'b0;
        if (hit) m_stall = 1'b0;
        chk({tag, " R6 ready"}, 64'(replay_ready), 64'(hit));
        if (hit) chk({tag, " R6 ready idx"}, 64'(replay_load_idx), 64'(idx));
        chk({tag, " R6 stall"}, 64'(stall_active), 64'(m_stall));
        @(posedge clk); #1;
        chk({tag, " R6 ready pulse"}, 64'(replay_ready), 64'd0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7041));
        clear_sq();
        repeat (3) @(posedge clk);
        #1;
        chk("R9 done", 64'(done), 0);
        chk("R9 busy", 64'(busy), 0);
        chk("R9 stall", 64'(stall_active), 0);
        chk("R9 ready", 64'(replay_ready), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: recorded index equals writeback pointer
        set_ld(0, 4, 10, 1, 3, 3, 0, 0, 0);
        run_load("D1", 0);
        // R2 R3: empty slot skipped, offset shift
        q_size[2] = 4'd8; q_data[2] = 64'h1122334455667788;
        set_ld(2, 2, 11, 1, 4, 0, 0, 0, 0);
        run_load("D2", 0);
        // R1: youngest covering store wins
        q_size[3] = 4'd4; q_data[3] = 64'h00000000AABBCCDD;
        set_ld(0, 4, 12, 1, 4, 0, 0, 0, 0);
        run_load("D3", 0);
        // R1: wraparound past zero
        clear_sq();
        q_size[7] = 4'd8; q_addr[7] = 16'd8; q_data[7] = 64'hCAFEF00D12345678;
        set_ld(12, 4, 13, 1, 1, 5, 0, 0, 0);
        run_load("D4", 0);
        // R4: written partial store passed over
        clear_sq();
        q_size[3] = 4'd2; q_addr[3] = 16'd4; q_wr[3] = 1'b1;
        q_size[2] = 4'd8; q_data[2] = 64'h0123456789ABCDEF;
        set_ld(4, 4, 14, 1, 4, 0, 0, 0, 0);
        run_load("D5", 0);
        // R4 R5: unwritten partial store stalls
        q_wr[3] = 1'b0;
        set_ld(4, 4, 50, 3, 4, 0, 0, 0, 0);
        run_load("D6", 0);
        // R5: younger load keeps record
        q_seq[3] = 16'd777;
        set_ld(4, 4, 60, 5, 4, 0, 0, 0, 0);
        run_load("D7", 0);
        // R5: older load replaces record
        set_ld(4, 4, 40, 7, 4, 0, 0, 0, 0);
        run_load("D8", 0);
        // R6: stray then matching writeback
        wb_pulse("D9a", 16'd5);
        wb_pulse("D9b", m_st_seq);
        // R7: speculative uncached load refused, no stall taken
        set_ld(4, 4, 20, 2, 4, 0, 1, 1, 0);
        run_load("D10", 0);
        // R7: uncached at head and commit is scanned
        q_size[3] = 4'd0;
        set_ld(4, 4, 21, 2, 4, 0, 1, 1, 1);
        run_load("D11", 0);
        // R8: request held while busy is ignored
        set_ld(0, 8, 22, 2, 4, 0, 0, 0, 0);
        run_load("D12", 1);

        // random vectors
        for (int v = 0; v < 400; v++) begin
            int szs [5] = '{0, 1, 2, 4, 8};
            for (int i = 0; i < SQD; i++) begin
                int s = szs[$urandom % 5];
                q_size[i] = SZW'(s);
                q_addr[i] = AW'(($urandom % 24) & ~((s == 0 ? 1 : s) - 1));
                q_data[i] = {$urandom, $urandom};
                q_seq[i]  = SEQW'($urandom % 1000);
                q_wr[i]   = ($urandom % 4) == 0;
            end
            begin
                int ls = szs[1 + $urandom % 4];
                set_ld(($urandom % 24) & ~(ls - 1), ls, $urandom % 200, $urandom % LQD,
                       $urandom % SQD, $urandom % SQD, ($urandom % 8) == 0,
                       ($urandom % 2) == 1, ($urandom % 2) == 1);
            end
            run_load("RND", 0);
            if (($urandom % 3) == 0)
                wb_pulse("RNDWB", (($urandom % 2) == 1) ? m_st_seq : SEQW'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule